// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries words from a write clock domain to an independent read clock domain. Each side has its own enable. Four active-low status outputs report the fill level: full, empty, a near-full warning and a near-empty warning. The two warning thresholds are offsets held in registers inside the block. Software loads them and reads them back through the ordinary data ports while the `load` input is high.

Each offset is two data words wide. It is accessed as a fixed cycle of four slots: near-empty offset low half, near-empty offset high half, near-full offset low half, near-full offset high half. A pointer on the write side steps through the cycle for loads, and a pointer on the read side steps through it for read-backs. Both pointers wrap after the fourth slot.

A static mode input selects between two read behaviours. In registered-read mode a word appears on `dout` only after a read edge. In look-ahead mode the oldest word drops into the output register without a read, and `rd_en` consumes it. That output register adds one word of storage.

Top module: `dcfifo_progflag`

## Requirements
- R1: After reset `full_n`=1, `empty_n`=0, `afull_n`=1 and `aempty_n`=0, and both offsets hold DEF_OFS (3): the four read-back slots return 3, 0, 3, 0.
- R2: Words leave in the order they were written. In registered-read mode `dout` shows the next word right after the read-clock edge that samples `rd_en`=1 with `load`=0.
- R3: `full_n` is low exactly when DEPTH (16) words sit in memory. `empty_n` is low exactly when no word can be read. A write while full is dropped and does not appear in the read stream.
- R4: A read while empty leaves `dout` and the read pointer unchanged.
- R5: `afull_n` is updated on write-clock edges only. It is low when the write-side memory count is at least DEPTH minus m, where m is the near-full offset, and high when the count is DEPTH-(m+1) or less.
- R6: `aempty_n` is updated on read-clock edges only. It is low when the readable count is at most n, where n is the near-empty offset.
- R7: With `load`=1 and `wr_en`=1, each write-clock edge stores `din` into the next offset slot in the order near-empty low, near-empty high, near-full low, near-full high. Nothing enters the memory.
- R8: With `load`=1 and `rd_en`=1, each read-clock edge puts the next offset slot on `dout`, in the same order. No data word is consumed.
- R9: In look-ahead mode (`fwft`=1) the oldest word reaches `dout` without a read, and `empty_n` is high while it is held there.
- R10: In look-ahead mode the block holds DEPTH+1 words before a write is dropped.
- R11: Pointers cross clock domains as Gray codes through two flip-flop stages. A Gray pointer changes by at most one bit per edge, and `empty_n` is still low at the first read-clock falling edge after a write edge.
- R12: Both slot pointers wrap to the first slot after the fourth access and return to the first slot on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft | input | 1 | 1 = look-ahead mode; change only while in reset |
| load | input | 1 | Redirects enabled accesses to the offset slots |
| wr_en | input | 1 | Write enable (write domain) |
| din | input | DW | Write data or offset half |
| rd_en | input | 1 | Read enable (read domain) |
| dout | output | DW | Read data or offset half |
| full_n | output | 1 | Low when memory is full |
| empty_n | output | 1 | Low when nothing is readable |
| afull_n | output | 1 | Low at or above the near-full threshold |
| aempty_n | output | 1 | Low at or below the near-empty threshold |

## Verification
Data and offset read-backs are registered once, so they are due right after the read edge. The bench raises `rd_en` at a read-clock falling edge and samples `dout` at the next falling edge. A change in one domain reaches the other domain's flags after one pointer register, two synchronizer stages and one flag register, which is four clocks at most, plus one more in look-ahead mode for the fetch. Every flag check therefore waits ten cycles after its burst ends. The one exception samples `empty_n` at the first read falling edge after a write, when it must still be low.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } ofs_slot_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t q, d;
    logic [W-1:0] b;

    always_comb begin
        d    = q;
        d.s1 = gray_in;
        d.s2 = q.s1;
        b    = '0;
        b[W-1] = q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ q.s2[i];
        end
        bin_out = b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr
    import dcf_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int DEF_OFS = 3
) (
    input  logic            wclk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            wr_en,
    input  logic [DW-1:0]   din,
    input  logic [AW:0]     rbin_s,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output logic [AW:0]     wbin,
    output logic [AW:0]     wgray,
    output logic            full,
    output logic            afull,
    output logic [2*DW-1:0] ae_ofs,
    output logic [2*DW-1:0] af_ofs
);
    localparam int PW    = AW + 1;
    localparam int OW    = 2 * DW;
    localparam int DEPTH = 1 << AW;
    localparam logic AF_RST = (DEF_OFS >= DEPTH);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
        logic [OW-1:0] ae;
        logic [OW-1:0] af;
        ofs_slot_e     slot;
    } st_t;

    st_t q, d;
    logic push, ldw;
    logic [PW-1:0] cnt_d;

    always_comb begin
        d    = q;
        push = wr_en && !load && !q.full;
        ldw  = wr_en && load;
        if (push) d.bin = q.bin + 1'b1;
        d.gray = d.bin ^ (d.bin >> 1);
        if (ldw) begin
            case (q.slot)
                SLOT_AE_LO: d.ae[DW-1:0]  = din;
                SLOT_AE_HI: d.ae[OW-1:DW] = din;
                SLOT_AF_LO: d.af[DW-1:0]  = din;
                default:    d.af[OW-1:DW] = din;
            endcase
            d.slot = ofs_slot_e'(q.slot + 2'd1);
        end
        cnt_d   = d.bin - rbin_s;
        d.full  = (cnt_d == PW'(DEPTH));
        d.afull = ({1'b0, d.af} + (OW+1)'(cnt_d)) >= (OW+1)'(DEPTH);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            q.bin   <= '0;
            q.gray  <= '0;
            q.full  <= 1'b0;
            q.afull <= AF_RST;
            q.ae    <= OW'(DEF_OFS);
            q.af    <= OW'(DEF_OFS);
            q.slot  <= SLOT_AE_LO;
        end else begin
            q <= d;
        end
    end

    assign we     = push;
    assign waddr  = q.bin[AW-1:0];
    assign wbin   = q.bin;
    assign wgray  = q.gray;
    assign full   = q.full;
    assign afull  = q.afull;
    assign ae_ofs = q.ae;
    assign af_ofs = q.af;
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd
    import dcf_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic            rclk,
    input  logic            rst_n,
    input  logic            fwft,
    input  logic            load,
    input  logic            rd_en,
    input  logic [DW-1:0]   rdata,
    input  logic [AW:0]     wbin_s,
    input  logic [2*DW-1:0] ae_ofs,
    input  logic [2*DW-1:0] af_ofs,
    output logic [AW-1:0]   raddr,
    output logic [AW:0]     rbin,
    output logic [AW:0]     rgray,
    output logic [DW-1:0]   dout,
    output logic            empty,
    output logic            aempty
);
    localparam int PW = AW + 1;
    localparam int OW = 2 * DW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] data;
        logic          ovld;
        logic          show;
        logic [DW-1:0] ofsv;
        ofs_slot_e     slot;
        logic          empty;
        logic          aempty;
    } st_t;

    st_t q, d;
    logic          mem_has, fetch, pop_fw, ldr;
    logic [PW-1:0] cnt_d;

    always_comb begin
        d       = q;
        mem_has = (wbin_s != q.bin);
        ldr     = load && rd_en;
        pop_fw  = fwft && rd_en && !load && q.ovld;
        if (fwft) fetch = mem_has && (!q.ovld || (rd_en && !load));
        else      fetch = !q.empty && rd_en && !load;
        if (fetch) begin
            d.data = rdata;
            d.bin  = q.bin + 1'b1;
        end
        d.gray = d.bin ^ (d.bin >> 1);
        if (!fwft)       d.ovld = 1'b0;
        else if (fetch)  d.ovld = 1'b1;
        else if (pop_fw) d.ovld = 1'b0;
        if (ldr) begin
            case (q.slot)
                SLOT_AE_LO: d.ofsv = ae_ofs[DW-1:0];
                SLOT_AE_HI: d.ofsv = ae_ofs[OW-1:DW];
                SLOT_AF_LO: d.ofsv = af_ofs[DW-1:0];
                default:    d.ofsv = af_ofs[OW-1:DW];
            endcase
            d.slot = ofs_slot_e'(q.slot + 2'd1);
        end
        d.show   = load && (q.show || rd_en);
        cnt_d    = (wbin_s - d.bin) + PW'(d.ovld);
        d.empty  = fwft ? !d.ovld : (cnt_d == '0);
        d.aempty = ({1'b0, ae_ofs} >= (OW+1)'(cnt_d));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.slot   <= SLOT_AE_LO;
            q.empty  <= 1'b1;
            q.aempty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign raddr  = q.bin[AW-1:0];
    assign rbin   = q.bin;
    assign rgray  = q.gray;
    assign dout   = q.show ? q.ofsv : q.data;
    assign empty  = q.empty;
    assign aempty = q.aempty;
endmodule

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag #(
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int DEF_OFS = 3
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft,
    input  logic          load,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          empty_n,
    output logic          afull_n,
    output logic          aempty_n
);
    localparam int PW = AW + 1;
    localparam int OW = 2 * DW;

    logic          we, full, afull, empty, aempty;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rdata;
    logic [PW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s;
    logic [OW-1:0] ae_ofs, af_ofs;

    dcf_wr #(.DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .load(load), .wr_en(wr_en), .din(din),
        .rbin_s(rbin_s), .we(we), .waddr(waddr), .wbin(wbin), .wgray(wgray),
        .full(full), .afull(afull), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
    );

    dcf_rd #(.DW(DW), .AW(AW)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .load(load), .rd_en(rd_en),
        .rdata(rdata), .wbin_s(wbin_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .raddr(raddr), .rbin(rbin), .rgray(rgray), .dout(dout),
        .empty(empty), .aempty(aempty)
    );

    assign full_n   = !full;
    assign empty_n  = !empty;
    assign afull_n  = !afull;
    assign aempty_n = !aempty;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int PW = 5
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          fwft,
    input logic          load,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          empty_n,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && wr_en && !load) |=> (wbin == $past(wbin)))
        else $error("write pointer moved while full"); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft && !empty_n && rd_en && !load) |=> (rbin == $past(rbin)))
        else $error("read pointer moved while empty"); // R4

    AST_LOAD_NO_PUSH: assert property (@(posedge wclk) disable iff (!rst_n)
        (load && wr_en) |=> (wbin == $past(wbin)))
        else $error("offset load pushed a word"); // R7

    AST_LOAD_NO_POP: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft && load) |=> (rbin == $past(rbin)))
        else $error("offset read-back popped a word"); // R8

    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1))
        else $error("write gray pointer changed in more than one bit"); // R11

    AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
        1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1))
        else $error("read gray pointer changed in more than one bit"); // R11
endmodule

bind dcfifo_progflag dcf_chk #(.PW(AW + 1)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .load(load),
    .wr_en(wr_en), .rd_en(rd_en), .full_n(full_n), .empty_n(empty_n),
    .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_progflag_tb_top.sv
module dcfifo_progflag_tb_top;
    localparam int DW = 16, AW = 4, DEPTH = 16, DEF = 3;

    logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0, load = 0, wr_en = 0, rd_en = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic full_n, empty_n, afull_n, aempty_n;

    always #2 wclk = ~wclk;
    initial begin #1; forever #2 rclk = ~rclk; end

    dcfifo_progflag #(.DW(DW), .AW(AW), .DEF_OFS(DEF)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .load(load),
        .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout),
        .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n), .aempty_n(aempty_n)
    );

    int total = 0, bad = 0, head = 0, tail = 0, cnt = 0, mn = DEF, mm = DEF, serial = 0;
    logic [DW-1:0] mq [128];
    logic [DW-1:0] lastd = '0;
    bit done = 0;

    // phase table: writes, reads, expected fill afterwards
    localparam int NPH = 6;
    localparam int TW [NPH] = '{4, 0, 12, 3, 0, 0};
    localparam int TR [NPH] = '{0, 2, 0, 0, 18, 2};
    localparam int TC [NPH] = '{4, 2, 14, 16, 0, 0};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cap();
        return fwft ? DEPTH + 1 : DEPTH;
    endfunction

    task automatic settle();
        repeat (10) @(negedge wclk);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 0; fwft = m; load = 0; wr_en = 0; rd_en = 0;
        repeat (3) @(negedge wclk);
        rst_n = 1;
        head = 0; tail = 0; cnt = 0; mn = DEF; mm = DEF; lastd = '0;
        settle();
    endtask

    task automatic wr_burst(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge wclk);
            wr_en = 1; din = DW'(16'hA000 + serial);
            if (cnt < cap()) begin mq[tail % 128] = din; tail++; cnt++; end
            serial++;
        end
        @(negedge wclk); wr_en = 0;
    endtask

    task automatic rd_one();
        @(negedge rclk); rd_en = 1;
        @(negedge rclk); rd_en = 0;
        if (!fwft) begin
            if (cnt > 0) begin lastd = mq[head % 128]; head++; cnt--; end
            check("R2/R4 read data", dout, lastd);
        end else begin
            if (cnt > 0) begin head++; cnt--; end
            if (cnt > 0) check("R9 look-ahead data", dout, mq[head % 128]);
            else         check("R3 empty after last pop", empty_n, 0);
        end
    endtask

    task automatic chk_flags(input int c);
        int wc;
        wc = (fwft && c > 0) ? c - 1 : c;
        check("R3 full_n", full_n, !(wc == DEPTH));
        check("R3 empty_n", empty_n, c > 0);
        check("R5 afull_n", afull_n, !(wc + mm >= DEPTH));
        check("R6 aempty_n", aempty_n, !(c <= mn));
    endtask

    task automatic phase(input int w, input int r, input int c);
        wr_burst(w);
        repeat (r) rd_one();
        settle();
        chk_flags(c);
    endtask

    task automatic rb(input string req, input logic [DW-1:0] exp);
        @(negedge rclk); load = 1; rd_en = 1;
        @(negedge rclk); rd_en = 0;
        check(req, dout, exp);
    endtask

    task automatic lw(input logic [DW-1:0] v);
        @(negedge wclk); load = 1; wr_en = 1; din = v;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(0);
        check("R1 full_n", full_n, 1);
        check("R1 empty_n", empty_n, 0);
        check("R1 afull_n", afull_n, 1);
        check("R1 aempty_n", aempty_n, 0);
        rb("R1/R8 slot0", 3); rb("R1/R8 slot1", 0);
        rb("R1/R8 slot2", 3); rb("R1/R8 slot3", 0);
        @(negedge rclk); load = 0;
        settle();

        for (int p = 0; p < NPH; p++) phase(TW[p], TR[p], TC[p]);

        // R11: a fresh write is not visible at the first read falling edge
        @(negedge wclk); wr_en = 1; din = 16'h5A5A;
        mq[tail % 128] = din; tail++; cnt++;
        @(posedge wclk); #0.5 wr_en = 0;
        @(negedge rclk);
        check("R11 empty_n still low", empty_n, 0);
        settle();
        rd_one();
        settle();

        // R7 offset load through the write port
        lw(5); lw(0); lw(2); lw(0);
        @(negedge wclk); wr_en = 0; load = 0;
        mn = 5; mm = 2;
        settle();
        check("R7 load stores no word", empty_n, 0);
        rb("R8 slot0", 5); rb("R8 slot1", 0); rb("R8 slot2", 2); rb("R8 slot3", 0);
        rb("R12 wrap to slot0", 5);
        @(negedge rclk); load = 0;
        settle();
        phase(5, 0, 5);
        phase(1, 0, 6);
        phase(8, 0, 14);
        phase(0, 1, 13);

        // R12: slot pointers restart after reset
        do_reset(0);
        lw(7);
        @(negedge wclk); wr_en = 0; load = 0;
        settle();
        rb("R12 reset slot", 7);
        @(negedge rclk); load = 0;
        settle();

        // look-ahead mode
        do_reset(1);
        check("R1 fwft empty_n", empty_n, 0);
        wr_burst(1);
        settle();
        check("R9 empty_n high", empty_n, 1);
        check("R9 word on dout", dout, mq[head % 128]);
        wr_burst(17);
        settle();
        chk_flags(17);
        check("R10 holds depth+1", full_n, 0);
        repeat (17) rd_one();
        settle();
        chk_flags(0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule